// File: doc/BRIEF.md
# Interrupt Entry/Return Context Sequencer

This block is the processor-side half of maskable interrupt handling. Once the interrupt controller has chosen a source, it presents the source number together with the PC the handler must eventually return to. The sequencer then runs a fixed five-step entry and takes one clock per step:

1. It saves the return PC into a single saved-PC register.
2. It copies the live status word into a single saved-status register.
3. It writes the source's cause code into the low half of the cause register.
4. It raises the interrupt-disable flag and drops the exception-pending flag.
5. It loads the handler address and pulses a PC-load strobe.

A busy flag covers the whole entry, so the controller cannot issue another acknowledge during it.

When idle, the block also carries out these operations on the status word:

- Return: restores the PC and the status word from the saved copies in one cycle.
- Whole-word status write.
- Disable-interrupts: sets the interrupt-disable flag.
- Enable-interrupts: clears the interrupt-disable flag.

There is only one saved context. A second entry taken before software has copied the saved registers elsewhere overwrites them, and the first return point is lost.

Status bit positions: bit 5 is interrupt-disable (ID), bit 6 is exception-pending (EP) and bit 7 is non-maskable-pending (NP). With the default parameters:

| Parameter | Default | Meaning |
|---|---|---|
| `VEC_BASE` | 0x100 | Handler address is `VEC_BASE + src*16`. |
| `CODE_BASE` | 0x0100 | Cause code is `CODE_BASE + src*16`. |
| `CAUSE_HI_RST` | 0xA5C3 | Reset value of the upper cause half. |
| `STATUS_RST` | 0x20 | Reset value of the status word. |

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset the outputs hold these values: `status` = 0x0000_0020, `busy` = 0, `pc_load` = 0, `saved_pc` = 0, `saved_status` = 0 and `cause` = {CAUSE_HI_RST, 16'h0000}.
- R2: An acknowledge is accepted only while `busy` is 0. Starting in the cycle after acceptance, `busy` stays 1 for exactly 5 cycles. An acknowledge presented while `busy` is 1 has no effect.
- R3: After an entry, `saved_pc` equals the `ret_pc` value that was presented with the accepted acknowledge.
- R4: After an entry, `saved_status` equals the `status` value held just before acceptance.
- R5: After an entry, `cause[15:0]` equals CODE_BASE + src*16 and `cause[31:16]` is unchanged.
- R6: After an entry, `status` bit 5 (ID) is 1, bit 6 (EP) is 0 and every other bit is unchanged.
- R7: In the cycle that `busy` falls, `pc_load` is 1 for that single cycle and `pc_out` = VEC_BASE + src*16.
- R8: A return request accepted while idle sets `pc_out` = `saved_pc` and `status` = `saved_status` in the next cycle, with a one-cycle `pc_load`. If the saved status has bit 5 or bit 7 at 0, that bit is cleared.
- R9: While idle, a status write replaces all 32 bits of `status`, a disable request sets bit 5, and an enable request clears bit 5.
- R10: While `busy` is 1, return, status-write, disable and enable requests are ignored.
- R11: When several requests arrive in the same idle cycle, only one is served, in this order of priority: acknowledge, then return, then status write, then disable, then enable.
- R12: A second entry taken without software saving the context overwrites `saved_pc` and `saved_status`, so the next return resumes the second context rather than the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge from the interrupt controller |
| ack_src | input | SRC_W | Number of the acknowledged source |
| ret_pc | input | 32 | Return PC presented with the acknowledge |
| ret_req | input | 1 | Return-from-interrupt request |
| status_wr | input | 1 | Whole-word status write strobe |
| status_wdata | input | 32 | Data for the status write |
| di_req | input | 1 | Disable-interrupts request (sets bit 5) |
| ei_req | input | 1 | Enable-interrupts request (clears bit 5) |
| busy | output | 1 | High while the entry sequence runs |
| pc_load | output | 1 | One-cycle strobe that loads `pc_out` into the PC |
| pc_out | output | 32 | Handler address or restored return PC |
| status | output | 32 | Live status word |
| saved_pc | output | 32 | Saved return PC |
| saved_status | output | 32 | Saved status word |
| cause | output | 32 | Cause register; the low half holds the code |

## Verification
Entries are run for a middle source number, for the highest source number (63) and for source 0.

- The highest source tells a correct shift-and-add for the vector address and the cause code apart from a truncated one.
- Source 0 shows that the bases are applied.

The prior status words carry bit 6 set and assorted low bits. This separates a set-ID/clear-EP update, which leaves the other bits alone, from a whole-word overwrite.

Noise is injected on every other input while the block is busy. This tells gating by `busy` apart from gating by state. Simultaneous idle requests check the priority order. A back-to-back pair of entries shows that the second return context replaces the first.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int XLEN    = 32;
    localparam int HALF_W  = XLEN / 2;
    localparam int ID_BIT  = 5;
    localparam int EP_BIT  = 6;
    localparam int NP_BIT  = 7;
    localparam int STEP_SH = 4;   // sources are spaced 16 apart

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_PC,
        ST_SAVE_ST,
        ST_CODE,
        ST_FLAGS,
        ST_JUMP
    } seq_state_t;

    typedef struct packed {
        logic take_ack;
        logic do_ret;
        logic do_wr;
        logic do_di;
        logic do_ei;
    } op_sel_t;

    function automatic logic [XLEN-1:0] vec_addr(input logic [XLEN-1:0] base,
                                                 input logic [HALF_W-1:0] idx);
        return base + (XLEN'(idx) << STEP_SH);
    endfunction

    function automatic logic [HALF_W-1:0] cause_code(input logic [HALF_W-1:0] base,
                                                     input logic [HALF_W-1:0] idx);
        return base + (idx << STEP_SH);
    endfunction

endpackage

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
    import irq_ctx_pkg::*;
#(
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [SRC_W-1:0] src_in,
    input  logic [XLEN-1:0]  pc_in,
    output seq_state_t       state,
    output logic [SRC_W-1:0] src_q,
    output logic [XLEN-1:0]  rpc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            src_q <= '0;
            rpc_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SAVE_PC;
                        src_q <= src_in;
                        rpc_q <= pc_in;
                    end
                end
                ST_SAVE_PC: state <= ST_SAVE_ST;
                ST_SAVE_ST: state <= ST_CODE;
                ST_CODE:    state <= ST_FLAGS;
                ST_FLAGS:   state <= ST_JUMP;
                default:    state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctx_status.sv
module irq_ctx_status
    import irq_ctx_pkg::*;
#(
    parameter logic [31:0] STATUS_RST = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_t      state,
    input  op_sel_t         ops,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] saved_status,
    output logic [XLEN-1:0] status
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= STATUS_RST;
        end else if (state == ST_FLAGS) begin
            status[ID_BIT] <= 1'b1;
            status[EP_BIT] <= 1'b0;
        end else if (ops.do_ret) begin
            status <= saved_status;
        end else if (ops.do_wr) begin
            status <= wdata;
        end else if (ops.do_di) begin
            status[ID_BIT] <= 1'b1;
        end else if (ops.do_ei) begin
            status[ID_BIT] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank
    import irq_ctx_pkg::*;
#(
    parameter int          SRC_W        = 6,
    parameter logic [31:0] VEC_BASE     = 32'h0000_0100,
    parameter logic [15:0] CODE_BASE    = 16'h0100,
    parameter logic [15:0] CAUSE_HI_RST = 16'hA5C3
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_t       state,
    input  logic             do_ret,
    input  logic [SRC_W-1:0] src_q,
    input  logic [XLEN-1:0]  rpc_q,
    input  logic [XLEN-1:0]  status,
    output logic [XLEN-1:0]  saved_pc,
    output logic [XLEN-1:0]  saved_status,
    output logic [XLEN-1:0]  cause,
    output logic [XLEN-1:0]  pc_out,
    output logic             pc_load
);

    logic [HALF_W-1:0] idx;
    assign idx = HALF_W'(src_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_pc     <= '0;
            saved_status <= '0;
            cause        <= {CAUSE_HI_RST, {HALF_W{1'b0}}};
            pc_out       <= '0;
            pc_load      <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            case (state)
                ST_SAVE_PC: saved_pc <= rpc_q;
                ST_SAVE_ST: saved_status <= status;
                ST_CODE:    cause[HALF_W-1:0] <= cause_code(CODE_BASE, idx);
                ST_JUMP: begin
                    pc_out  <= vec_addr(VEC_BASE, idx);
                    pc_load <= 1'b1;
                end
                default: begin
                    if (do_ret) begin
                        pc_out  <= saved_pc;
                        pc_load <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int          SRC_W        = 6,
    parameter logic [31:0] VEC_BASE     = 32'h0000_0100,
    parameter logic [15:0] CODE_BASE    = 16'h0100,
    parameter logic [15:0] CAUSE_HI_RST = 16'hA5C3,
    parameter logic [31:0] STATUS_RST   = 32'h0000_0020
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_valid,
    input  logic [SRC_W-1:0] ack_src,
    input  logic [31:0]      ret_pc,
    input  logic             ret_req,
    input  logic             status_wr,
    input  logic [31:0]      status_wdata,
    input  logic             di_req,
    input  logic             ei_req,
    output logic             busy,
    output logic             pc_load,
    output logic [31:0]      pc_out,
    output logic [31:0]      status,
    output logic [31:0]      saved_pc,
    output logic [31:0]      saved_status,
    output logic [31:0]      cause
);

    seq_state_t        state;
    op_sel_t           ops;
    logic [SRC_W-1:0]  src_q;
    logic [XLEN-1:0]   rpc_q;
    logic              idle;

    assign idle = (state == ST_IDLE);
    assign busy = ~idle;

    // fixed priority among requests seen in one idle cycle
    always_comb begin
        ops          = '0;
        ops.take_ack = idle & ack_valid;
        ops.do_ret   = idle & ~ack_valid & ret_req;
        ops.do_wr    = idle & ~ack_valid & ~ret_req & status_wr;
        ops.do_di    = idle & ~ack_valid & ~ret_req & ~status_wr & di_req;
        ops.do_ei    = idle & ~ack_valid & ~ret_req & ~status_wr & ~di_req & ei_req;
    end

    irq_ctx_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .accept (ops.take_ack),
        .src_in (ack_src),
        .pc_in  (ret_pc),
        .state  (state),
        .src_q  (src_q),
        .rpc_q  (rpc_q)
    );

    irq_ctx_status #(.STATUS_RST(STATUS_RST)) u_status (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .ops          (ops),
        .wdata        (status_wdata),
        .saved_status (saved_status),
        .status       (status)
    );

    irq_ctx_bank #(
        .SRC_W        (SRC_W),
        .VEC_BASE     (VEC_BASE),
        .CODE_BASE    (CODE_BASE),
        .CAUSE_HI_RST (CAUSE_HI_RST)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .do_ret       (ops.do_ret),
        .src_q        (src_q),
        .rpc_q        (rpc_q),
        .status       (status),
        .saved_pc     (saved_pc),
        .saved_status (saved_status),
        .cause        (cause),
        .pc_out       (pc_out),
        .pc_load      (pc_load)
    );

endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk #(
    parameter int          SRC_W     = 6,
    parameter logic [31:0] VEC_BASE  = 32'h0000_0100,
    parameter logic [15:0] CODE_BASE = 16'h0100
) (
    input logic             clk,
    input logic             rst,
    input logic             ack_valid,
    input logic [SRC_W-1:0] ack_src,
    input logic [31:0]      ret_pc,
    input logic             ret_req,
    input logic             status_wr,
    input logic             di_req,
    input logic             ei_req,
    input logic             busy,
    input logic             pc_load,
    input logic [31:0]      pc_out,
    input logic [31:0]      status,
    input logic [31:0]      saved_pc,
    input logic [31:0]      saved_status,
    input logic [31:0]      cause
);

    logic [SRC_W-1:0] exp_src;
    logic [2:0]       busy_cnt;
    logic             accept;

    assign accept = !busy && ack_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_src  <= '0;
            busy_cnt <= '0;
        end else begin
            if (accept) exp_src <= ack_src;
            busy_cnt <= busy ? busy_cnt + 3'd1 : 3'd0;
        end
    end

    p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < 3'd5));

    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == 3'd5));

    p_save_pc_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 (saved_pc == $past(ret_pc, 2)));

    p_cause_hi_r5: assert property (@(posedge clk) disable iff (rst)
        $stable(cause[31:16]));

    p_flags_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (status[5] && !status[6]));

    p_jump_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pc_load && pc_out == VEC_BASE + (32'(exp_src) << 4)
                         && cause[15:0] == CODE_BASE + (16'(exp_src) << 4)));

    p_return_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ack_valid && ret_req) |=>
            (pc_load && pc_out == $past(saved_pc) && status == $past(saved_status)));

    p_ei_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ack_valid && !ret_req && !status_wr && !di_req && ei_req) |=> !status[5]);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt < 3'd3) |=> $stable(status));

endmodule

bind irq_ctx_seq irq_ctx_chk #(
    .SRC_W     (SRC_W),
    .VEC_BASE  (VEC_BASE),
    .CODE_BASE (CODE_BASE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack_valid    (ack_valid),
    .ack_src      (ack_src),
    .ret_pc       (ret_pc),
    .ret_req      (ret_req),
    .status_wr    (status_wr),
    .di_req       (di_req),
    .ei_req       (ei_req),
    .busy         (busy),
    .pc_load      (pc_load),
    .pc_out       (pc_out),
    .status       (status),
    .saved_pc     (saved_pc),
    .saved_status (saved_status),
    .cause        (cause)
);

// File: tb/irq_ctx_seq_tb_top.sv
module irq_ctx_seq_tb_top;

    localparam int          SRC_W     = 6;
    localparam logic [31:0] VEC_BASE  = 32'h0000_0100;
    localparam logic [15:0] CODE_BASE = 16'h0100;
    localparam logic [15:0] CHI       = 16'hA5C3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ack_valid = 1'b0;
    logic [SRC_W-1:0] ack_src = '0;
    logic [31:0]      ret_pc = '0;
    logic             ret_req = 1'b0;
    logic             status_wr = 1'b0;
    logic [31:0]      status_wdata = '0;
    logic             di_req = 1'b0;
    logic             ei_req = 1'b0;
    logic             busy, pc_load;
    logic [31:0]      pc_out, status, saved_pc, saved_status, cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_ctx_seq #(.SRC_W(SRC_W), .VEC_BASE(VEC_BASE), .CODE_BASE(CODE_BASE),
                  .CAUSE_HI_RST(CHI)) dut_i (
        .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_src(ack_src),
        .ret_pc(ret_pc), .ret_req(ret_req), .status_wr(status_wr),
        .status_wdata(status_wdata), .di_req(di_req), .ei_req(ei_req),
        .busy(busy), .pc_load(pc_load), .pc_out(pc_out), .status(status),
        .saved_pc(saved_pc), .saved_status(saved_status), .cause(cause));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one full entry; noisy drives other inputs while busy
    task automatic t_entry(input logic [SRC_W-1:0] src, input logic [31:0] rpc, input bit noisy);
        logic [31:0] prior;
        prior = status;
        ack_valid = 1'b1; ack_src = src; ret_pc = rpc;
        tick();
        ack_valid = 1'b0;
        chk("R2 busy after accept", 32'(busy), 32'd1);
        if (noisy) begin
            ack_valid = 1'b1; ack_src = ~src; ret_pc = 32'hDEAD_0000;
            ret_req = 1'b1; status_wr = 1'b1; status_wdata = 32'hFFFF_FFFF;
            di_req = 1'b1; ei_req = 1'b1;
        end
        tick(); tick();
        ack_valid = 1'b0; ret_req = 1'b0; status_wr = 1'b0; di_req = 1'b0; ei_req = 1'b0;
        tick(); tick();
        chk("R2 busy in fifth cycle", 32'(busy), 32'd1);
        chk("R7 no early load", 32'(pc_load), 32'd0);
        tick();
        chk("R2 busy drops after five", 32'(busy), 32'd0);
        chk("R7 pc_load", 32'(pc_load), 32'd1);
        chk("R7 handler address", pc_out, VEC_BASE + (32'(src) << 4));
        chk("R3 saved pc", saved_pc, rpc);
        chk("R4 saved status", saved_status, prior);
        chk("R5 cause", cause, {CHI, CODE_BASE + (16'(src) << 4)});
        chk("R6 status flags", status, (prior | 32'h20) & ~32'h40);
        if (noisy) chk("R10 noise ignored, status", status, (prior | 32'h20) & ~32'h40);
        tick();
        chk("R7 pc_load one cycle", 32'(pc_load), 32'd0);
    endtask

    task automatic t_return(input logic [31:0] exp_pc, input logic [31:0] exp_st);
        ret_req = 1'b1;
        tick();
        ret_req = 1'b0;
        chk("R8 return pc", pc_out, exp_pc);
        chk("R8 return status", status, exp_st);
        chk("R8 return strobe", 32'(pc_load), 32'd1);
        tick();
        chk("R8 strobe one cycle", 32'(pc_load), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h20);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 pc_load", 32'(pc_load), 32'd0);
        chk("R1 saved pc", saved_pc, 32'd0);
        chk("R1 saved status", saved_status, 32'd0);
        chk("R1 cause", cause, {CHI, 16'h0});
    endtask

    task automatic t_status_ops();
        status_wr = 1'b1; status_wdata = 32'h0000_00C1;
        tick();
        status_wr = 1'b0;
        chk("R9 status write", status, 32'h0000_00C1);
        di_req = 1'b1;
        tick();
        di_req = 1'b0;
        chk("R9 disable sets bit 5", status, 32'h0000_00E1);
        ei_req = 1'b1;
        tick();
        ei_req = 1'b0;
        chk("R9 enable clears bit 5", status, 32'h0000_00C1);
    endtask

    task automatic t_priority();
        // return beats write: status comes from the saved copy
        ret_req = 1'b1; status_wr = 1'b1; status_wdata = 32'h1234_5678;
        tick();
        ret_req = 1'b0; status_wr = 1'b0;
        chk("R11 return over write", status, saved_status);
        // write beats disable: bit 5 stays as written (0)
        status_wr = 1'b1; status_wdata = 32'h0000_0003; di_req = 1'b1;
        tick();
        status_wr = 1'b0;
        chk("R11 write over disable", status, 32'h0000_0003);
        // disable beats enable
        ei_req = 1'b1;
        tick();
        di_req = 1'b0; ei_req = 1'b0;
        chk("R11 disable over enable", status, 32'h0000_0023);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_status_ops();                          // status = 0xC1
        t_entry(6'd3, 32'h0000_1000, 1'b1);      // status -> 0xA1
        t_return(32'h0000_1000, 32'h0000_00C1);  // R8: bit 5 back to 0, NP kept
        t_entry(6'd63, 32'h0000_4444, 1'b0);     // top source number
        t_priority();
        // R12: nested entry without save loses first context
        t_entry(6'd1, 32'h0000_2000, 1'b0);
        t_entry(6'd0, 32'h0000_3000, 1'b0);
        chk("R12 saved pc overwritten", saved_pc, 32'h0000_3000);
        chk("R12 saved status is first handler state", saved_status, 32'h0000_0023);
        t_return(32'h0000_3000, 32'h0000_0023);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule